// File: doc/BRIEF.md
# Minimum-PC Warp Reconvergence Selector

This block tracks a private program counter for each lane of a warp and decides, every cycle, which lanes issue next. The candidates are the lanes that have not exited. Among them it picks the smallest PC, and every lane sitting at that PC runs together as the active group. When the issue stage accepts an instruction it raises the advance strobe. If the instruction is a branch, each active lane writes back either the shared branch target or its own fall-through address, chosen by that lane's predicate bit. Any other instruction moves the active lanes to the next word.

Lanes merge without help. Two groups that reach the same address are selected together from then on. No reconvergence stack is kept and no marker instruction is needed. Code that places join points above the divergent paths leading to them rejoins correctly. A branch whose predicate is the same across the active group keeps that group whole.

The selection is registered. After an advance, the new PC and the new mask appear on the outputs in the next cycle. Because of this, advances can be issued back to back.

Top module: `reconv_sel`

## Requirements
- R1: After reset every lane PC is 0 and no lane has exited. The outputs are then pc_o = 0, active_o = all ones and done_o = 0.
- R2: pc_o equals the lowest PC among lanes that have not exited. active_o bit i is 1 exactly when lane i has not exited and its PC equals pc_o.
- R3: On an advance of a non-branch instruction (adv_i = 1, is_br_i = 0), every active lane that is not exiting increments its PC by 1, modulo 2^PC_W. The new selection appears in the cycle after the advance edge.
- R4: On an advance of a branch (is_br_i = 1), active lane i loads br_target_i when pred_i bit i is 1. When that bit is 0, lane i loads its PC + 1.
- R5: A branch whose predicate bits agree across all active lanes leaves the active group intact and moves it to one PC.
- R6: Lanes whose PCs become equal are selected together in the same active mask.
- R7: An advance never changes the PC or the exit state of a lane that is not in active_o.
- R8: On an advance, an active lane with exit_i bit i = 1 is marked exited and its PC is unchanged. An exited lane never becomes active again. exit_i bits of inactive lanes are ignored.
- R9: When every lane has exited, done_o = 1, active_o = 0 and pc_o = 0. This state persists until reset.
- R10: While adv_i = 0, pc_o, active_o and done_o hold their values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance strobe: the current instruction is issued for active_o |
| is_br_i | input | 1 | The issued instruction is a branch |
| br_target_i | input | PC_W | Branch target address |
| pred_i | input | LANES | Per-lane branch-taken predicate |
| exit_i | input | LANES | Per-lane exit request, honoured for active lanes on an advance |
| pc_o | output | PC_W | Selected (minimum) PC |
| active_o | output | LANES | Lanes issuing at pc_o |
| done_o | output | 1 | All lanes have exited |

## Verification
Two functions can act in the same cycle. One is the advance of the active group. The other is the merge of that group with a waiting group that it catches up to. The bench splits the warp with a half-taken forward branch, then advances the lagging half one word per cycle. On the cycle its PC reaches the other half's PC, the mask must widen to all lanes. Exit and branch handling are also combined: exit requests aimed at inactive lanes arrive during an advance of other lanes. Each expected PC and mask comes from a lane-level model that the bench keeps itself.

// File: rtl/reconv_pkg.sv
package reconv_pkg;
  parameter int unsigned NUM_LANES = 32;
  parameter int unsigned PC_WIDTH  = 16;
endpackage

// File: rtl/reconv_lane_regs.sv
module reconv_lane_regs #(
  parameter int unsigned LANES = reconv_pkg::NUM_LANES,
  parameter int unsigned PC_W  = reconv_pkg::PC_WIDTH
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  input  logic                        is_br_i,
  input  logic [PC_W-1:0]             br_target_i,
  input  logic [LANES-1:0]            pred_i,
  input  logic [LANES-1:0]            exit_i,
  input  logic [LANES-1:0]            act_i,
  output logic [LANES-1:0][PC_W-1:0]  pc_d_o,
  output logic [LANES-1:0]            fin_d_o
);
  logic [LANES-1:0][PC_W-1:0] pc_q;
  logic [LANES-1:0]           fin_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      pc_d_o[g]  = pc_q[g];
      fin_d_o[g] = fin_q[g];
      if (adv_i && act_i[g]) begin
        if (exit_i[g])                  fin_d_o[g] = 1'b1;
        else if (is_br_i && pred_i[g])  pc_d_o[g]  = br_target_i;
        else                            pc_d_o[g]  = pc_q[g] + 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q[g]  <= '0;
        fin_q[g] <= 1'b0;
      end else begin
        pc_q[g]  <= pc_d_o[g];
        fin_q[g] <= fin_d_o[g];
      end
    end
  end
endmodule

// File: rtl/reconv_min_tree.sv
module reconv_min_tree #(
  parameter int unsigned LANES = reconv_pkg::NUM_LANES,
  parameter int unsigned PC_W  = reconv_pkg::PC_WIDTH
) (
  input  logic [LANES-1:0][PC_W-1:0] pc_i,
  input  logic [LANES-1:0]           fin_i,
  output logic [PC_W-1:0]            min_pc_o,
  output logic                       all_fin_o
);
  localparam int unsigned LVLS = $clog2(LANES);
  localparam int unsigned KW   = PC_W + 1;

  // key = {exited, pc}: exited lanes sort above every live lane
  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int unsigned N = LANES >> l;
    logic [KW-1:0] k [N];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_n
        assign k[i] = {fin_i[i], pc_i[i]};
      end
    end else begin : g_node
      for (genvar i = 0; i < N; i++) begin : g_n
        assign k[i] = (g_lvl[l-1].k[2*i] <= g_lvl[l-1].k[2*i+1]) ?
                      g_lvl[l-1].k[2*i] : g_lvl[l-1].k[2*i+1];
      end
    end
  end

  assign all_fin_o = g_lvl[LVLS].k[0][KW-1];
  assign min_pc_o  = g_lvl[LVLS].k[0][PC_W-1:0];
endmodule

// File: rtl/reconv_sel.sv
module reconv_sel #(
  parameter int unsigned LANES = reconv_pkg::NUM_LANES,
  parameter int unsigned PC_W  = reconv_pkg::PC_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             is_br_i,
  input  logic [PC_W-1:0]  br_target_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] exit_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [LANES-1:0] active_o,
  output logic             done_o
);
  initial begin
    if (LANES < 2 || (LANES & (LANES - 1)) != 0)
      $error("LANES must be a power of two");
  end

  logic [LANES-1:0][PC_W-1:0] pc_d;
  logic [LANES-1:0]           fin_d;
  logic [PC_W-1:0]            min_pc;
  logic                       all_fin;
  logic [LANES-1:0]           hit;

  reconv_lane_regs #(.LANES(LANES), .PC_W(PC_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv_i),
    .is_br_i    (is_br_i),
    .br_target_i(br_target_i),
    .pred_i     (pred_i),
    .exit_i     (exit_i),
    .act_i      (active_o),
    .pc_d_o     (pc_d),
    .fin_d_o    (fin_d)
  );

  reconv_min_tree #(.LANES(LANES), .PC_W(PC_W)) i_tree (
    .pc_i     (pc_d),
    .fin_i    (fin_d),
    .min_pc_o (min_pc),
    .all_fin_o(all_fin)
  );

  // broadcast compare: every live lane at the minimum issues
  for (genvar g = 0; g < LANES; g++) begin : g_hit
    assign hit[g] = !fin_d[g] && (pc_d[g] == min_pc);
  end

  // selection is taken from next-state so it always matches the lane regs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o     <= '0;
      active_o <= '1;
      done_o   <= 1'b0;
    end else begin
      pc_o     <= all_fin ? '0 : min_pc;
      active_o <= hit;
      done_o   <= all_fin;
    end
  end
endmodule

// File: rtl/reconv_sel_chk.sv
module reconv_sel_chk #(
  parameter int unsigned LANES = reconv_pkg::NUM_LANES,
  parameter int unsigned PC_W  = reconv_pkg::PC_WIDTH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adv_i,
  input logic             is_br_i,
  input logic [PC_W-1:0]  br_target_i,
  input logic [LANES-1:0] pred_i,
  input logic [LANES-1:0] exit_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [LANES-1:0] active_o,
  input logic             done_o
);
  a_r9_done_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (active_o == '0 && pc_o == '0));

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r2_live_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> active_o != '0);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(pc_o) && $stable(active_o) && $stable(done_o)));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !is_br_i && !done_o && (exit_i & active_o) == '0)
    |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  a_r5_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && is_br_i && active_o == '1 && exit_i == '0 &&
     (pred_i == '1 || pred_i == '0)) |=> active_o == '1);
endmodule

bind reconv_sel reconv_sel_chk #(.LANES(LANES), .PC_W(PC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_i), .is_br_i(is_br_i),
  .br_target_i(br_target_i), .pred_i(pred_i), .exit_i(exit_i),
  .pc_o(pc_o), .active_o(active_o), .done_o(done_o)
);

// File: tb/test_reconv_sel.sv
`timescale 1ns/1ps
module test_reconv_sel;
  localparam int L = 32;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] pc;
    logic [L-1:0] mask;
    logic         done;
    string        tag;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic adv_i = 1'b0, is_br_i = 1'b0;
  logic [W-1:0] br_target_i = '0;
  logic [L-1:0] pred_i = '0, exit_i = '0;
  logic [W-1:0] pc_o;
  logic [L-1:0] active_o;
  logic done_o;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t sb_q[$];

  logic [W-1:0] m_pc [L];
  logic         m_fin [L];

  always #10 clk_i = ~clk_i;

  reconv_sel #(.LANES(L), .PC_W(W)) i_reconv_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_i), .is_br_i(is_br_i),
    .br_target_i(br_target_i), .pred_i(pred_i), .exit_i(exit_i),
    .pc_o(pc_o), .active_o(active_o), .done_o(done_o)
  );

  function automatic exp_t model_sel(string tag);
    exp_t e;
    logic found = 1'b0;
    e.pc = '0; e.mask = '0; e.tag = tag;
    for (int i = 0; i < L; i++)
      if (!m_fin[i] && (!found || m_pc[i] < e.pc)) begin
        e.pc = m_pc[i]; found = 1'b1;
      end
    for (int i = 0; i < L; i++) e.mask[i] = !m_fin[i] && m_pc[i] == e.pc;
    e.done = !found;
    return e;
  endfunction

  task automatic step(bit adv, bit br, logic [W-1:0] tgt,
                      logic [L-1:0] pred, logic [L-1:0] ex, string tag);
    exp_t cur;
    @(negedge clk_i);
    adv_i = adv; is_br_i = br; br_target_i = tgt; pred_i = pred; exit_i = ex;
    cur = model_sel(tag);
    if (adv)
      for (int i = 0; i < L; i++)
        if (cur.mask[i]) begin
          if (ex[i])              m_fin[i] = 1'b1;
          else if (br && pred[i]) m_pc[i]  = tgt;
          else                    m_pc[i]  = m_pc[i] + 1'b1;
        end
    @(posedge clk_i); #1;
    sb_q.push_back(model_sel(tag));
  endtask

  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (pc_o !== e.pc || active_o !== e.mask || done_o !== e.done) begin
        bad++;
        $display("FAIL %s: pc=%0d mask=%h done=%b expected pc=%0d mask=%h done=%b",
                 e.tag, pc_o, active_o, done_o, e.pc, e.mask, e.done);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < L; i++) begin m_pc[i] = '0; m_fin[i] = 1'b0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    total++; // R1 reset state
    if (pc_o !== '0 || active_o !== '1 || done_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: pc=%0d mask=%h done=%b expected pc=0 mask=ffffffff done=0",
               pc_o, active_o, done_o);
    end
    step(0, 1, 16'd77, '1, '1, "R10 idle");
    for (int k = 0; k < 3; k++) step(1, 0, '0, '0, '0, "R3 step");
    step(1, 1, 16'd20, 32'h0000_FFFF, '0, "R4 split");
    for (int k = 0; k < 15; k++) step(1, 0, '0, '0, '0, "R7 waiting half");
    step(1, 0, '0, '0, '0, "R6 merge");
    step(1, 1, 16'd40, '1, '0, "R5 uniform taken");
    step(1, 1, 16'd99, '0, '0, "R5 uniform not taken");
    step(1, 1, 16'd10, 32'hAAAA_AAAA, '0, "R4 backward split");
    step(1, 0, '0, '0, 32'hAAAA_AAAA, "R8 exit odd");
    step(1, 1, 16'd50, 32'h0000_0005, '0, "R4 two lanes");
    step(1, 0, '0, '0, 32'h0000_0001, "R8 inactive exit ignored");
    step(0, 0, '0, '0, '1, "R10 idle exit");
    step(1, 0, '0, '0, '1, "R8 exit group");
    step(1, 0, '0, '0, '1, "R9 all exited");
    step(1, 1, 16'd3, '1, '0, "R9 stays done");
    @(negedge clk_i); adv_i = 1'b0;
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule